// File: doc/BRIEF.md
# Multi-Format Byte Multiplier

This block is the multiply unit of a small 8-bit processor datapath. It takes two byte operands and a three-bit format code, and returns a 16-bit product together with a carry flag and a zero flag. The operands can be read as unsigned or signed integers. They can also be read as fixed-point fractions with one integer bit and seven fraction bits. In that case the product is moved left by one place, so it comes out with one integer bit and fifteen fraction bits.

A one-cycle start pulse launches an operation. The edge that samples start captures the operands. The next edge registers the result and raises a one-cycle done strobe. Busy is high only in the cycle between these two edges. A start in that cycle is ignored. A new operation may be started in the same cycle that done is high, so the unit can accept one operation every two cycles. The outputs keep the last result until the next one is written.

Top module: `mfmul_top`

## Requirements
- R1: Format code 3'b000 multiplies both operands as unsigned integers. Code 3'b011 is handled in the same way. The 16-bit result is the exact product.
- R2: Format code 3'b001 multiplies both operands as two's-complement signed integers. The result is the exact 16-bit two's-complement product.
- R3: Format code 3'b010 multiplies op_a_i as signed by op_b_i as unsigned. The result is the exact 16-bit two's-complement product.
- R4: When fmt_i[2] is 1, the sign handling of fmt_i[1:0] is kept, and the 16-bit raw product is shifted left by one bit. This makes bit 0 of the result zero.
- R5: When start_i is sampled high at an idle edge, done_o is high for exactly one cycle after the following edge. In that same cycle product_o and the flags carry the result.
- R6: busy_o is high for exactly the one cycle between the sampling edge and the result edge.
- R7: A start_i that is sampled while busy_o is high is ignored. The result of the operation in flight is not changed, and no second done_o follows.
- R8: carry_o is bit 15 of the raw product. In integer formats this equals bit 15 of product_o. In fractional formats it is the bit that was shifted out.
- R9: zero_o is 1 exactly when the final 16-bit product_o is zero.
- R10: Signed fractional 0x80 × 0x80 gives product_o = 0x8000 with carry_o = 0. The result is not saturated.
- R11: While rst is high, and after it is released, busy_o, done_o, product_o, carry_o and zero_o are all 0.
- R12: product_o, carry_o and zero_o keep their value until the next done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launches an operation when the unit is idle |
| fmt_i | input | 3 | Format code: bit 2 selects fractional, bits 1:0 select the sign mode |
| op_a_i | input | 8 | First operand (the signed one in mixed mode) |
| op_b_i | input | 8 | Second operand |
| busy_o | output | 1 | High while an operation is in flight |
| done_o | output | 1 | One-cycle strobe when the result is valid |
| product_o | output | 16 | Registered product |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
On every cycle, the assertions check the timing handshake:
- busy lasts a single cycle and is always followed by done;
- a start that arrives while busy neither extends busy nor blocks done;
- the result registers do not change between strobes.

In the same way, they check that bit 0 of a fractional result is zero, that the integer carry matches the top bit of the product, and that the zero flag matches the registered product.

Only the bench's scenarios can show that the product values are correct. To do this, the bench compares random and directed operand pairs in every format against products it computes itself. This includes the extreme signed values, the -1.0 × -1.0 overflow and the zero results.

// File: rtl/mfmul_pkg.sv
package mfmul_pkg;
  // sign handling, fmt[1:0]
  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_ALT = 2'b11
  } sign_mode_e;

  localparam int FRAC_BIT = 2;
  localparam int FMT_W    = 3;
endpackage

// File: rtl/mfmul_ctrl.sv
module mfmul_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic capture_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, done_q;

  assign capture_o = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= capture_o;
      done_q <= busy_q;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_busy_single_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q);
  p_done_follows_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> done_q);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> (!done_q || $past(busy_q)));
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> (done_q && !busy_q));
endmodule

// File: rtl/mfmul_opnd_ext.sv
module mfmul_opnd_ext
  import mfmul_pkg::*;
#(
  parameter int W    = 8,
  parameter bit IS_A = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [1:0]          sign_i,
  input  logic [W-1:0]        op_i,
  output logic signed [W:0]   ext_o
);
  logic is_signed;

  generate
    if (IS_A) begin : g_a
      assign is_signed = (sign_i == SGN_SS) || (sign_i == SGN_SU);
    end else begin : g_b
      assign is_signed = (sign_i == SGN_SS);
    end
  endgenerate

  logic signed [W:0] ext_q;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= '0;
    else if (en_i) ext_q <= {is_signed & op_i[W-1], op_i};
  end

  assign ext_o = ext_q;
endmodule

// File: rtl/mfmul_arith.sv
module mfmul_arith #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               frac_i,
  input  logic signed [W:0]  a_i,
  input  logic signed [W:0]  b_i,
  output logic [2*W-1:0]     res_o,
  output logic               carry_o,
  output logic               zero_o
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] raw;
  logic [PW-1:0]        shaped;
  logic [PW-1:0]        res_q;
  logic                 carry_q, zero_q, frac_q;

  assign raw    = PW'(a_i) * PW'(b_i);
  assign shaped = frac_i ? {raw[PW-2:0], 1'b0} : raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      frac_q  <= 1'b0;
    end else if (en_i) begin
      res_q   <= shaped;
      carry_q <= raw[PW-1];
      zero_q  <= (shaped == '0);
      frac_q  <= frac_i;
    end
  end

  assign res_o   = res_q;
  assign carry_o = carry_q;
  assign zero_o  = zero_q;

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(res_q) && $stable(carry_q) && $stable(zero_q)));
  p_frac_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    frac_q |-> (res_q[0] == 1'b0));
  p_int_carry_r8: assert property (@(posedge clk) disable iff (rst)
    !frac_q |-> (carry_q == res_q[PW-1]));
  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> (res_q == '0));
endmodule

// File: rtl/mfmul_top.sv
module mfmul_top
  import mfmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [W-1:0]     op_a_i,
  input  logic [W-1:0]     op_b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2*W-1:0]   product_o,
  output logic             carry_o,
  output logic             zero_o
);
  logic capture, busy;
  logic signed [W:0] a_ext, b_ext;
  logic frac_q;

  mfmul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .capture_o(capture), .busy_o(busy), .done_o(done_o)
  );

  mfmul_opnd_ext #(.W(W), .IS_A(1'b1)) u_ext_a (
    .clk(clk), .rst(rst), .en_i(capture), .sign_i(fmt_i[1:0]),
    .op_i(op_a_i), .ext_o(a_ext)
  );

  mfmul_opnd_ext #(.W(W), .IS_A(1'b0)) u_ext_b (
    .clk(clk), .rst(rst), .en_i(capture), .sign_i(fmt_i[1:0]),
    .op_i(op_b_i), .ext_o(b_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) frac_q <= 1'b0;
    else if (capture) frac_q <= fmt_i[FRAC_BIT];
  end

  mfmul_arith #(.W(W)) u_arith (
    .clk(clk), .rst(rst), .en_i(busy), .frac_i(frac_q),
    .a_i(a_ext), .b_i(b_ext),
    .res_o(product_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  assign busy_o = busy;

  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && product_o == '0 && !carry_o && !zero_o));
  p_no_start_no_busy_r5: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !busy_o);
endmodule

// File: tb/mfmul_top_tb_top.sv
module mfmul_top_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic start_i;
  logic [2:0] fmt_i;
  logic [7:0] op_a_i, op_b_i;
  logic busy_o, done_o, carry_o, zero_o;
  logic [15:0] product_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mfmul_top dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .fmt_i(fmt_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .busy_o(busy_o), .done_o(done_o),
    .product_o(product_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  // returns {carry, zero, product}
  function automatic logic [17:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [2:0] fmt);
    int ai, bi, p;
    logic [15:0] raw, res;
    ai = (fmt[1:0] == 2'b01 || fmt[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    bi = (fmt[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p = ai * bi;
    raw = p[15:0];
    res = fmt[2] ? {raw[14:0], 1'b0} : raw;
    return {raw[15], (res == 16'h0), res};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] fmt);
    if (fmt[2]) return "R4";
    case (fmt[1:0])
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] fmt);
    logic [17:0] e;
    e = model(a, b, fmt);
    @(negedge clk);
    start_i = 1'b1; op_a_i = a; op_b_i = b; fmt_i = fmt;
    @(negedge clk);
    start_i = 1'b0; op_a_i = ~a; op_b_i = ~b;
    chk(busy_o && !done_o, "R6 busy", {busy_o, done_o}, 2'b10);
    @(negedge clk);
    chk(done_o && !busy_o, "R5 done", {busy_o, done_o}, 2'b01);
    chk(product_o == e[15:0], req_of(fmt), product_o, e[15:0]);
    chk(carry_o == e[17], "R8 carry", carry_o, e[17]);
    chk(zero_o == e[16], "R9 zero", zero_o, e[16]);
    @(negedge clk);
    chk(!done_o && product_o == e[15:0] && carry_o == e[17],
        "R12 hold", {done_o, product_o}, {1'b0, e[15:0]});
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000 && !finished) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] e;
    void'($urandom(32'd1234));
    rst = 1'b1; start_i = 1'b0; fmt_i = 3'b0; op_a_i = '0; op_b_i = '0;
    repeat (3) @(negedge clk);
    // R11: outputs during and after reset
    chk(!busy_o && !done_o && product_o == 0 && !carry_o && !zero_o,
        "R11 reset", {busy_o, done_o, product_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && product_o == 0, "R11 after", {busy_o, done_o, product_o}, 0);

    // directed corners
    run_op(8'hFF, 8'hFF, 3'b000);     // R1
    run_op(8'hFF, 8'hFF, 3'b011);     // R1 alternate code
    run_op(8'h80, 8'h80, 3'b001);     // R2
    run_op(8'h80, 8'h7F, 3'b001);     // R2
    run_op(8'hFF, 8'hFF, 3'b010);     // R3
    run_op(8'h80, 8'hFF, 3'b010);     // R3
    run_op(8'h00, 8'h5A, 3'b001);     // R9 zero
    run_op(8'h80, 8'h00, 3'b110);     // R9 zero frac
    run_op(8'h40, 8'h40, 3'b101);     // R4 signed frac
    run_op(8'hFF, 8'hFF, 3'b100);     // R4 unsigned frac, carry out
    run_op(8'hC0, 8'hFF, 3'b110);     // R4 mixed frac
    // R10: -1.0 x -1.0 signed fractional
    run_op(8'h80, 8'h80, 3'b101);
    chk(product_o == 16'h8000 && carry_o == 1'b0, "R10 overflow",
        {carry_o, product_o}, 17'h08000);

    // R7: second start while busy is ignored
    e = model(8'h12, 8'h34, 3'b000);
    @(negedge clk);
    start_i = 1'b1; op_a_i = 8'h12; op_b_i = 8'h34; fmt_i = 3'b000;
    @(negedge clk);
    op_a_i = 8'hAA; op_b_i = 8'hBB; fmt_i = 3'b001;  // start stays high
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && !busy_o && product_o == e[15:0], "R7 ignored",
        {busy_o, done_o, product_o}, {2'b01, e[15:0]});
    @(negedge clk);
    chk(!done_o && !busy_o && product_o == e[15:0], "R7 no second done",
        {busy_o, done_o, product_o}, {2'b00, e[15:0]});

    // back-to-back: new start in the done cycle (R5)
    @(negedge clk);
    start_i = 1'b1; op_a_i = 8'h03; op_b_i = 8'h05; fmt_i = 3'b000;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; op_a_i = 8'hFE; op_b_i = 8'h03; fmt_i = 3'b001;
    chk(done_o && product_o == 16'd15, "R5 first of pair", product_o, 16'd15);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R5 second accepted", busy_o, 1'b1);
    @(negedge clk);
    chk(done_o && product_o == 16'hFFFA, "R2 second of pair", product_o, 16'hFFFA);

    // constrained random over all format codes
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b;
      logic [2:0] f;
      a = 8'($urandom);
      b = 8'($urandom);
      f = 3'($urandom_range(7, 0));
      if (i % 16 == 0) a = 8'h80;
      if (i % 16 == 1) b = 8'h7F;
      run_op(a, b, f);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule